// File: doc/BRIEF.md
# Address-Pattern Nonvolatile Command Detector

This block monitors the bus cycles of a static memory and picks out two hidden commands encoded as runs of six back-to-back reads to fixed addresses. One run asks a downstream sequencer to copy the volatile array into nonvolatile storage (store). The other asks it to copy nonvolatile contents back into the array (recall). There is no command register and no opcode. The only trigger is the order of read addresses the host issues.

Each bus cycle is marked by a one-clock `cycleValid` strobe, qualified by `chipSel` and by the `writeCycle` level. Progress through a pattern is held in a small counter. On the sixth matching read, the block raises `storeReq` or `recallReq` in that same clock, together with `outDisable`, which tells the array's output drivers to stay in high impedance for that cycle. The first five reads of a pattern are ordinary reads and return data. The output-enable level plays no part in recognition, so the block has no input for it.

Top module: `nvCmdSniffer`

## Requirements
- R1: After reset, and after any reset that lands part way through a pattern, progress is zero and `storeReq`, `recallReq` and `outDisable` are low. A lone sixth address after reset raises no request.
- R2: Six selected reads whose addresses are 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0 raise `storeReq` during the strobe cycle of the sixth read.
- R3: Six selected reads whose addresses are 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0C63 raise `recallReq` during the strobe cycle of the sixth read. `storeReq` and `recallReq` are never high together.
- R4: Only address bits 13:0 are compared. Bit 14 may take any value in any of the six reads.
- R5: A selected cycle with `writeCycle` high clears progress, so the pattern must restart from its first address.
- R6: A selected read that does not match the next expected address clears progress. If that address equals the first pattern address (0x0E38), progress restarts at one. A sixth address that is neither 0x0FC0 nor 0x0C63 raises no request.
- R7: Clocks with `cycleValid` low, and strobes with `chipSel` low (read or write), neither advance nor clear progress.
- R8: `outDisable` is high only in the cycle that raises a request. It stays low during the first five reads of a pattern.
- R9: A request lasts one clock. Progress is zero afterwards, so repeating only the final address or addresses does not raise another request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleValid | input | 1 | One-clock strobe marking a bus cycle |
| chipSel | input | 1 | Chip selected for this cycle (active high) |
| writeCycle | input | 1 | High for a write cycle, low for a read |
| addr | input | 15 | Bus address of the cycle |
| storeReq | output | 1 | One-clock store request to the sequencer |
| recallReq | output | 1 | One-clock recall request to the sequencer |
| outDisable | output | 1 | Keep data outputs in high impedance this cycle |

## Verification
The case that needs care is the sixth read. In that one clock the block raises a request and forces the outputs off, and it also clears its own progress, so the next strobe can start a fresh pattern. The bench drives back-to-back strobes so that the firing read is followed at once by reads of the last pattern addresses. It then checks that the request and the output-disable flag appear together only in the firing cycle and that no second request follows. A second case places a deselected strobe carrying the sixth address between the fifth and sixth reads. That strobe must neither fire nor disturb progress, and the selected read that follows must fire.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
  localparam int SEQ_LEN = 6;
  localparam int CMP_W   = 14;
  localparam int CNT_W   = $clog2(SEQ_LEN);

  localparam logic [CMP_W-1:0] STORE_LAST  = 14'h0FC0;
  localparam logic [CMP_W-1:0] RECALL_LAST = 14'h0C63;

  // shared prefix of both patterns, entries 0 .. SEQ_LEN-2
  function automatic logic [CMP_W-1:0] prefixEntry(input int idx);
    case (idx)
      0:       prefixEntry = 14'h0E38;
      1:       prefixEntry = 14'h31C7;
      2:       prefixEntry = 14'h03E0;
      3:       prefixEntry = 14'h3C1F;
      default: prefixEntry = 14'h303F;
    endcase
  endfunction

  // control -> datapath
  typedef struct packed {
    logic advance;
    logic restart;
    logic clear;
  } progStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic hitNext;
    logic hitFirst;
    logic atLast;
    logic hitStore;
    logic hitRecall;
  } matchFlags_t;
endpackage

// File: rtl/nvseq_datapath.sv
module nvseq_datapath
  import nvseq_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      addr,
  input  progStrobe_t            strobes,
  output matchFlags_t            flags,
  output logic [CNT_W-1:0]       progress
);
  logic [CMP_W-1:0]   cmpAddr;
  logic [SEQ_LEN-1:0] entryHit;

  assign cmpAddr = addr[CMP_W-1:0];

  genvar gi;
  generate
    for (gi = 0; gi < SEQ_LEN - 1; gi++) begin : g_prefix
      assign entryHit[gi] = (cmpAddr == prefixEntry(gi));
    end
  endgenerate
  assign entryHit[SEQ_LEN-1] = 1'b0;

  always_comb begin
    flags.hitNext   = entryHit[progress];
    flags.hitFirst  = entryHit[0];
    flags.atLast    = (progress == CNT_W'(SEQ_LEN - 1));
    flags.hitStore  = (cmpAddr == STORE_LAST);
    flags.hitRecall = (cmpAddr == RECALL_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                progress <= '0;
    else if (strobes.clear)   progress <= '0;
    else if (strobes.restart) progress <= CNT_W'(1);
    else if (strobes.advance) progress <= progress + CNT_W'(1);
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.advance, strobes.restart, strobes.clear})) else $error("strobe clash"); // R6
endmodule

// File: rtl/nvseq_control.sv
module nvseq_control
  import nvseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cycleValid,
  input  logic        chipSel,
  input  logic        writeCycle,
  input  matchFlags_t flags,
  output progStrobe_t strobes,
  output logic        storeReq,
  output logic        recallReq,
  output logic        outDisable
);
  logic active, readCyc, fireStore, fireRecall, fire;

  assign active     = cycleValid && chipSel;
  assign readCyc    = active && !writeCycle;
  assign fireStore  = readCyc && flags.atLast && flags.hitStore;
  assign fireRecall = readCyc && flags.atLast && flags.hitRecall;
  assign fire       = fireStore || fireRecall;

  always_comb begin
    strobes.advance = readCyc && flags.hitNext;
    strobes.restart = readCyc && !flags.hitNext && !fire && flags.hitFirst;
    strobes.clear   = active && !strobes.advance && !strobes.restart;
  end

  assign storeReq   = fireStore;
  assign recallReq  = fireRecall;
  assign outDisable = fire;

  AST_FIRE_IS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq || recallReq) |-> (cycleValid && chipSel && !writeCycle)) else $error("request outside read"); // R5
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({storeReq, recallReq})) else $error("both requests"); // R3
endmodule

// File: rtl/nvCmdSniffer.sv
module nvCmdSniffer
  import nvseq_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleValid,
  input  logic              chipSel,
  input  logic              writeCycle,
  input  logic [ADDR_W-1:0] addr,
  output logic              storeReq,
  output logic              recallReq,
  output logic              outDisable
);
  progStrobe_t      strobes;
  matchFlags_t      flags;
  logic [CNT_W-1:0] progress;

  nvseq_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .addr(addr),
    .strobes(strobes), .flags(flags), .progress(progress)
  );

  nvseq_control ctl_i (
    .clk(clk), .rstN(rstN), .cycleValid(cycleValid), .chipSel(chipSel),
    .writeCycle(writeCycle), .flags(flags), .strobes(strobes),
    .storeReq(storeReq), .recallReq(recallReq), .outDisable(outDisable)
  );

  AST_WRITE_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (cycleValid && chipSel && writeCycle) |=> (progress == '0)) else $error("write kept progress"); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(cycleValid && chipSel) |=> $stable(progress)) else $error("idle moved progress"); // R7
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq || recallReq) |=> (!storeReq && !recallReq && progress == '0)) else $error("request not a pulse"); // R9
  AST_DIS_ON_SIXTH: assert property (@(posedge clk) disable iff (!rstN)
    outDisable |-> (progress == CNT_W'(SEQ_LEN - 1))) else $error("disable before sixth"); // R8
endmodule

// File: tb/nvCmdSniffer_tb.sv
module nvCmdSniffer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleValid = 1'b0, chipSel = 1'b0, writeCycle = 1'b0;
  logic [14:0] addr = '0;
  logic storeReq, recallReq, outDisable;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  nvCmdSniffer dut_i (
    .clk(clk), .rstN(rstN), .cycleValid(cycleValid), .chipSel(chipSel),
    .writeCycle(writeCycle), .addr(addr),
    .storeReq(storeReq), .recallReq(recallReq), .outDisable(outDisable)
  );

  typedef struct packed {
    int v; int s; int w; logic [14:0] a; int st; int rc; int od; int rq;
  } vec_t;

  localparam int NV = 46;
  localparam vec_t VECS [NV] = '{
    // R2 store pattern
    '{1,1,0,15'h0E38,0,0,0,2}, '{1,1,0,15'h31C7,0,0,0,2}, '{1,1,0,15'h03E0,0,0,0,8},
    '{1,1,0,15'h3C1F,0,0,0,8}, '{1,1,0,15'h303F,0,0,0,8}, '{1,1,0,15'h0FC0,1,0,1,2},
    // R3 recall with bit 14 set in some reads (R4)
    '{1,1,0,15'h4E38,0,0,0,4}, '{1,1,0,15'h31C7,0,0,0,4}, '{1,1,0,15'h43E0,0,0,0,4},
    '{1,1,0,15'h3C1F,0,0,0,4}, '{1,1,0,15'h303F,0,0,0,4}, '{1,1,0,15'h4C63,0,1,1,3},
    // R9 tail addresses alone after a request
    '{1,1,0,15'h303F,0,0,0,9}, '{1,1,0,15'h0C63,0,0,0,9},
    // R5 write aborts
    '{1,1,0,15'h0E38,0,0,0,5}, '{1,1,0,15'h31C7,0,0,0,5}, '{1,1,0,15'h03E0,0,0,0,5},
    '{1,1,1,15'h3C1F,0,0,0,5}, '{1,1,0,15'h3C1F,0,0,0,5}, '{1,1,0,15'h303F,0,0,0,5},
    '{1,1,0,15'h0FC0,0,0,0,5},
    // R7 deselected / idle cycles ignored
    '{1,1,0,15'h0E38,0,0,0,7}, '{1,1,0,15'h31C7,0,0,0,7}, '{1,0,0,15'h1234,0,0,0,7},
    '{0,1,0,15'h0000,0,0,0,7}, '{1,0,1,15'h0E38,0,0,0,7}, '{1,1,0,15'h03E0,0,0,0,7},
    '{1,1,0,15'h3C1F,0,0,0,7}, '{1,1,0,15'h303F,0,0,0,7}, '{1,0,0,15'h0C63,0,0,0,7},
    '{1,1,0,15'h0C63,0,1,1,7},
    // R6 restart at one on first address
    '{1,1,0,15'h0E38,0,0,0,6}, '{1,1,0,15'h31C7,0,0,0,6}, '{1,1,0,15'h0E38,0,0,0,6},
    '{1,1,0,15'h31C7,0,0,0,6}, '{1,1,0,15'h03E0,0,0,0,6}, '{1,1,0,15'h3C1F,0,0,0,6},
    '{1,1,0,15'h303F,0,0,0,6}, '{1,1,0,15'h0FC0,1,0,1,6},
    // R6 wrong sixth address
    '{1,1,0,15'h0E38,0,0,0,6}, '{1,1,0,15'h31C7,0,0,0,6}, '{1,1,0,15'h03E0,0,0,0,6},
    '{1,1,0,15'h3C1F,0,0,0,6}, '{1,1,0,15'h303F,0,0,0,6}, '{1,1,0,15'h0123,0,0,0,6},
    '{1,1,0,15'h0C63,0,0,0,6}
  };

  task automatic check(input string tag, input logic st, input logic rc, input logic od);
    checks++;
    if (storeReq !== st || recallReq !== rc || outDisable !== od) begin
      failures++;
      $display("FAIL %s: got st=%b rc=%b od=%b expected st=%b rc=%b od=%b",
               tag, storeReq, recallReq, outDisable, st, rc, od);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic w, input logic [14:0] a);
    @(negedge clk);
    cycleValid = v; chipSel = s; writeCycle = w; addr = a;
    #5;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    // R1 reset state, even with the sixth address presented
    drive(1'b1, 1'b1, 1'b0, 15'h0FC0);
    check("R1 in reset", 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 15'h0000);
    rstN = 1'b1;
    drive(1'b1, 1'b1, 1'b0, 15'h0FC0);
    check("R1 lone sixth after reset", 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].v != 0, VECS[i].s != 0, VECS[i].w != 0, VECS[i].a);
      check($sformatf("R%0d row %0d", VECS[i].rq, i),
            VECS[i].st != 0, VECS[i].rc != 0, VECS[i].od != 0);
    end

    // R9 idle cycle right after a request
    drive(1'b1, 1'b1, 1'b0, 15'h0E38); drive(1'b1, 1'b1, 1'b0, 15'h31C7);
    drive(1'b1, 1'b1, 1'b0, 15'h03E0); drive(1'b1, 1'b1, 1'b0, 15'h3C1F);
    drive(1'b1, 1'b1, 1'b0, 15'h303F); drive(1'b1, 1'b1, 1'b0, 15'h0FC0);
    check("R9 fire", 1'b1, 1'b0, 1'b1);
    drive(1'b0, 1'b1, 1'b0, 15'h0FC0);
    check("R9 pulse ends", 1'b0, 1'b0, 1'b0);

    // R1 reset mid-pattern
    drive(1'b1, 1'b1, 1'b0, 15'h0E38); drive(1'b1, 1'b1, 1'b0, 15'h31C7);
    drive(1'b1, 1'b1, 1'b0, 15'h03E0); drive(1'b1, 1'b1, 1'b0, 15'h3C1F);
    drive(1'b1, 1'b1, 1'b0, 15'h303F);
    drive(1'b0, 1'b0, 1'b0, 15'h0000);
    rstN = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 15'h0000);
    rstN = 1'b1;
    drive(1'b1, 1'b1, 1'b0, 15'h0FC0);
    check("R1 reset mid pattern", 1'b0, 1'b0, 1'b0);

    drive(1'b0, 1'b0, 1'b0, 15'h0000);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: got running expected finished");
      summary();
      $finish;
    end
  end
endmodule